// File: doc/BRIEF.md
# Serial Crosspoint Configuration Loader

This block is the serial programming front end of a crosspoint switch controller. It watches four slow pins (a serial clock, a serial data input, an active-low chip select and a format select) with a much faster system clock. From them it assembles either a full configuration image that covers every output, or a single short word that retargets one output. When a frame closes properly it presents the staged per-output settings and a one-cycle valid strobe to the configuration bank that commits them later.

The loader keeps one shift chain as long as a full image. The chain's oldest bit leaves on a serial data output so several devices can share one data line in a chain. When the chain is overfilled, the earliest bits leave first, and a long frame leaves the last full image in place. A frame opens when chip select goes low, is armed by the next serial clock rising edge, takes one bit on every falling edge after that, and closes only when chip select has returned high and the serial clock makes one more rising edge.

Top module: `xpt_serial_loader`

## Requirements
- R1: After reset every output's staged setting is input 0 and off (field value 5'b10000), `cfg_valid_o` is low, `cfg_mask_o` is zero and `sdo_o` is low.
- R2: While `cs_n_i` is high, activity on `sck_i` and `sdi_i` shifts nothing into the chain and stages nothing: `sdo_o` and the staged settings stay as they were.
- R3: With `mode_i` low, a frame of exactly 40 bits updates every output. Bit j of the frame (sent j-th) becomes bit j of `cfg_o`, where output k holds its input address in bits 5k..5k+3 (LSB first) and its off flag in bit 5k+4 (1 = off, 0 = on). `cfg_mask_o` is all ones.
- R4: With `mode_i` high, a frame of exactly 8 bits updates one output. Sent bits 0..2 give the output number (LSB first), bits 3..6 the input address (LSB first) and bit 7 the off flag. Only that output's field changes and `cfg_mask_o` has only that output's bit set.
- R5: In addressed format a frame of any length other than 8 bits is dropped and leaves all staged settings unchanged.
- R6: In serial format a frame of fewer than 40 bits is dropped.
- R7: In serial format a frame longer than 40 bits stages the last 40 bits received.
- R8: A frame takes effect only on the first serial clock rising edge after chip select has returned high. `cfg_valid_o` then pulses for one system clock, and it does not pulse before that edge.
- R9: `sdo_o` always shows the oldest bit of the 40-bit chain and moves on each captured falling edge, so the bits sent out are the chain's earlier contents followed by the new stream in the order sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sck_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Chip select pin, active low |
| sdi_i | input | 1 | Serial data input pin, sampled on serial clock falling edges |
| mode_i | input | 1 | Format select: 0 = full image, 1 = single addressed word |
| sdo_o | output | 1 | Oldest bit of the shift chain, for chaining devices |
| cfg_o | output | 40 | Staged settings, five bits per output |
| cfg_mask_o | output | 8 | Outputs updated by the last accepted frame |
| cfg_valid_o | output | 1 | One-cycle strobe when a frame is accepted |

## Verification
Each pin passes two synchronizer flops and one edge flop, and the chain or the staged settings are written one cycle after the edge is seen. So `sdo_o` settles about four system clocks after a serial clock falling edge, and `cfg_valid_o` with the new `cfg_o` appears about four system clocks after the closing rising edge. The bench holds each serial clock phase for eight system clocks. It compares `sdo_o` only at the end of a high phase, well after the previous falling edge. It counts valid strobes with a monitor and checks the count and `cfg_o` ten system clocks after each frame closes. That is after the result is due and before anything else changes.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_ARM   = 2'd1,
    LD_RECV  = 2'd2,
    LD_CLOSE = 2'd3
  } ld_state_e;
endpackage

// File: rtl/xpt_pin_sync.sv
module xpt_pin_sync #(
  parameter int          W         = 4,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
      prev_q <= RESET_VAL;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign rise_o[i] =  sync_q[i] & ~prev_q[i];
    assign fall_o[i] = ~sync_q[i] &  prev_q[i];
  end

  assign level_o = sync_q;
endmodule

// File: rtl/xpt_frame_ctl.sv
module xpt_frame_ctl
  import xpt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_s,
  input  logic             sck_rise,
  input  logic             sck_fall,
  output logic             shift_stb_o,
  output logic             close_stb_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ld_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    cnt_en      = 1'b0;
    shift_stb_o = 1'b0;
    close_stb_o = 1'b0;
    case (state_q)
      LD_IDLE: begin
        if (!cs_n_s) state_d = LD_ARM;
      end
      LD_ARM: begin
        if (cs_n_s) begin
          state_d = LD_IDLE;
        end else if (sck_rise) begin
          state_d = LD_RECV;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      LD_RECV: begin
        if (cs_n_s) begin
          state_d = LD_CLOSE;
        end else if (sck_fall) begin
          shift_stb_o = 1'b1;
          if (cnt_q != CNT_MAX) begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
      end
      LD_CLOSE: begin
        if (!cs_n_s) begin
          state_d = LD_ARM;
        end else if (sck_rise) begin
          close_stb_o = 1'b1;
          state_d     = LD_IDLE;
        end
      end
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign bit_cnt_o = cnt_q;

  // R8: a frame can only close after chip select was seen high
  assert_close_after_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    close_stb_o |-> $past(cs_n_s));

  // R7: the bit count never goes backwards within one frame
  assert_count_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_RECV && $past(state_q) == LD_RECV) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/xpt_load_chain.sv
module xpt_load_chain #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_stb,
  input  logic         din,
  output logic [W-1:0] chain_o
);
  logic [W-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {din, chain_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chain_q <= '0;
    else if (shift_stb) chain_q <= chain_d;
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/xpt_stage_bank.sv
module xpt_stage_bank #(
  parameter int NUM_OUT = 8,
  parameter int IN_AW   = 4,
  parameter int OUT_AW  = 3,
  parameter int CNT_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         close_stb,
  input  logic                         mode_s,
  input  logic [CNT_W-1:0]             bit_cnt,
  input  logic [NUM_OUT*(IN_AW+1)-1:0] chain,
  output logic [NUM_OUT*(IN_AW+1)-1:0] cfg_o,
  output logic [NUM_OUT-1:0]           mask_o,
  output logic                         valid_o
);
  localparam int FIELD_W    = IN_AW + 1;
  localparam int FRAME_BITS = NUM_OUT * FIELD_W;
  localparam int WORD_BITS  = OUT_AW + FIELD_W;
  localparam logic [FIELD_W-1:0] FIELD_RST = {1'b1, {IN_AW{1'b0}}};

  logic [FRAME_BITS-1:0] cfg_q, cfg_d;
  logic [NUM_OUT-1:0]    mask_q, mask_d;
  logic                  valid_q, valid_d;
  logic                  full_ok, word_ok;
  logic [WORD_BITS-1:0]  word;
  logic [OUT_AW-1:0]     word_out;
  logic [FIELD_W-1:0]    word_field;

  assign full_ok    = close_stb & ~mode_s & (bit_cnt >= CNT_W'(FRAME_BITS));
  assign word_ok    = close_stb &  mode_s & (bit_cnt == CNT_W'(WORD_BITS));
  assign word       = chain[FRAME_BITS-1 -: WORD_BITS];
  assign word_out   = word[OUT_AW-1:0];
  assign word_field = word[WORD_BITS-1:OUT_AW];

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    always_comb begin
      mask_d[k] = full_ok | (word_ok & (word_out == OUT_AW'(k)));
      if (full_ok)
        cfg_d[k*FIELD_W +: FIELD_W] = chain[k*FIELD_W +: FIELD_W];
      else if (mask_d[k])
        cfg_d[k*FIELD_W +: FIELD_W] = word_field;
      else
        cfg_d[k*FIELD_W +: FIELD_W] = cfg_q[k*FIELD_W +: FIELD_W];
    end
  end

  assign valid_d = |mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= {NUM_OUT{FIELD_RST}};
      mask_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (valid_d) begin
        cfg_q  <= cfg_d;
        mask_q <= mask_d;
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign mask_o  = mask_q;
  assign valid_o = valid_q;

  // R3, R4: an accepted frame touches either every output or exactly one
  assert_mask_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ((&mask_q) || ($countones(mask_q) == 1)));

  // R8: the valid strobe lasts a single system clock
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R5, R6: settings change only together with the valid strobe
  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(cfg_q));
endmodule

// File: rtl/xpt_serial_loader.sv
module xpt_serial_loader #(
  parameter int NUM_OUT = 8,
  parameter int IN_AW   = 4,
  parameter int OUT_AW  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sck_i,
  input  logic                         cs_n_i,
  input  logic                         sdi_i,
  input  logic                         mode_i,
  output logic                         sdo_o,
  output logic [NUM_OUT*(IN_AW+1)-1:0] cfg_o,
  output logic [NUM_OUT-1:0]           cfg_mask_o,
  output logic                         cfg_valid_o
);
  localparam int FRAME_BITS = NUM_OUT * (IN_AW + 1);
  localparam int CNT_W      = $clog2(2 * FRAME_BITS) + 1;
  localparam int P_SCK  = 0;
  localparam int P_CSN  = 1;
  localparam int P_SDI  = 2;
  localparam int P_MODE = 3;

  logic       rst_meta_q, rst_sync_q;
  logic [3:0] pins, lvl, rise, fall;
  logic       shift_stb, close_stb;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign pins = {mode_i, sdi_i, cs_n_i, sck_i};

  xpt_pin_sync #(.W(4), .RESET_VAL(4'b0010)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .pin_i   (pins),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  xpt_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .cs_n_s      (lvl[P_CSN]),
    .sck_rise    (rise[P_SCK]),
    .sck_fall    (fall[P_SCK]),
    .shift_stb_o (shift_stb),
    .close_stb_o (close_stb),
    .bit_cnt_o   (bit_cnt)
  );

  xpt_load_chain #(.W(FRAME_BITS)) u_chain (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .shift_stb (shift_stb),
    .din       (lvl[P_SDI]),
    .chain_o   (chain)
  );

  xpt_stage_bank #(
    .NUM_OUT (NUM_OUT),
    .IN_AW   (IN_AW),
    .OUT_AW  (OUT_AW),
    .CNT_W   (CNT_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .close_stb (close_stb),
    .mode_s    (lvl[P_MODE]),
    .bit_cnt   (bit_cnt),
    .chain     (chain),
    .cfg_o     (cfg_o),
    .mask_o    (cfg_mask_o),
    .valid_o   (cfg_valid_o)
  );

  assign sdo_o = chain[0];

  // R2: with chip select held high the chain output does not move
  assert_cs_high_frozen_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (lvl[P_CSN] && $past(lvl[P_CSN])) |=> $stable(sdo_o));

  // R9: the chain output moves only after a captured falling edge
  assert_sdo_moves_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$past(fall[P_SCK]) |-> $stable(sdo_o));
endmodule

// File: tb/xpt_serial_loader_tb.sv
module xpt_serial_loader_tb;
  localparam int HALF = 8;
  localparam logic [39:0] IMG_A = 40'h8E_3A5C_71B2;
  localparam logic [39:0] IMG_B = 40'h3C_96F0_A51D;
  localparam logic [39:0] IMG_C = 40'h51_27E4_9B3A;
  localparam logic [39:0] IMG_D = 40'hA7_0C1F_64E9;
  // [48] mode, [47:40] bit count, [39:0] bits in send order (bit 0 first)
  localparam int NVEC = 7;
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b0, 8'd40, IMG_A},
    {1'b1, 8'd8,  32'd0, 8'h4D},
    {1'b1, 8'd7,  32'd0, 8'h4D},
    {1'b1, 8'd9,  32'd0, 8'h33},
    {1'b0, 8'd39, IMG_C},
    {1'b0, 8'd40, IMG_B},
    {1'b1, 8'd8,  32'd0, 8'hF8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0, mode = 1'b0;
  logic        sdo;
  logic [39:0] cfg;
  logic [7:0]  mask;
  logic        valid;

  int checks = 0;
  int fails = 0;
  int pend_cnt = 0;
  logic [39:0] m_cfg;
  logic [39:0] m_chain;
  int sdo_err;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xpt_serial_loader u_dut (
    .clk (clk), .rst_n (rst_n), .sck_i (sck), .cs_n_i (cs_n), .sdi_i (sdi),
    .mode_i (mode), .sdo_o (sdo), .cfg_o (cfg), .cfg_mask_o (mask),
    .cfg_valid_o (valid)
  );

  always @(negedge clk) if (valid) pend_cnt <= pend_cnt + 1;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic close_rise();
    sck = 1'b1; wait_cyc(HALF);
    sck = 1'b0; wait_cyc(HALF);
  endtask

  // sends n bits of data (bit 0 first); watch_sdo compares sdo before each fall
  task automatic send(input logic md, input int n, input logic [79:0] data,
                      input bit do_close, input bit watch_sdo);
    mode = md;
    cs_n = 1'b0; wait_cyc(HALF);
    sck = 1'b1;
    for (int i = 0; i < n; i++) begin
      sdi = data[i];
      wait_cyc(HALF);
      if (watch_sdo && sdo !== m_chain[0]) sdo_err++;
      m_chain = {data[i], m_chain[39:1]};
      sck = 1'b0; wait_cyc(HALF);
      if (i != n - 1) sck = 1'b1;
    end
    cs_n = 1'b1; wait_cyc(HALF);
    if (do_close) close_rise();
  endtask

  function automatic logic [39:0] apply(input logic [39:0] cur, input logic md,
                                        input int n, input logic [39:0] d);
    logic [39:0] r = cur;
    if (!md && n == 40) r = d;
    else if (md && n == 8) r[d[2:0]*5 +: 5] = d[7:3];
    return r;
  endfunction

  initial begin
    m_chain = '0;
    m_cfg = {8{5'b10000}};
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    // R1: reset state
    check(cfg === m_cfg, "R1 cfg", cfg, m_cfg);
    check(valid === 1'b0 && mask === 8'h00, "R1 valid/mask", {31'd0, valid, mask}, 40'd0);
    check(sdo === 1'b0, "R1 sdo", {39'd0, sdo}, 40'd0);

    // R3 R4 R5 R6: table of frames
    for (int v = 0; v < NVEC; v++) begin
      automatic logic       md = VEC[v][48];
      automatic int         n  = int'(VEC[v][47:40]);
      automatic logic [39:0] d = VEC[v][39:0];
      automatic int         exp_p;
      automatic logic [39:0] nxt = apply(m_cfg, md, n, d);
      exp_p = ((!md && n == 40) || (md && n == 8)) ? 1 : 0;
      pend_cnt = 0;
      send(md, n, {40'd0, d}, 1'b1, 1'b0);
      wait_cyc(10);
      m_cfg = nxt;
      check(pend_cnt == exp_p, md ? "R4/R5 valid count" : "R3/R6 valid count",
            40'(pend_cnt), 40'(exp_p));
      check(cfg === m_cfg, md ? "R4/R5 cfg" : "R3/R6 cfg", cfg, m_cfg);
      if (exp_p == 1) begin
        automatic logic [7:0] em = md ? (8'h01 << d[2:0]) : 8'hFF;
        check(mask === em, md ? "R4 mask" : "R3 mask", {32'd0, mask}, {32'd0, em});
      end
    end

    // R2: clock and data activity with chip select high
    begin
      automatic logic s0 = sdo;
      pend_cnt = 0;
      sdi = ~sdo;
      for (int i = 0; i < 12; i++) close_rise();
      wait_cyc(6);
      check(sdo === s0 && pend_cnt == 0 && cfg === m_cfg, "R2 ignored",
            {cfg[38:0], sdo}, {m_cfg[38:0], s0});
    end

    // R8: no effect until the extra rising edge after chip select rises
    pend_cnt = 0;
    send(1'b1, 8, {72'd0, 8'b0_0110_010}, 1'b0, 1'b0);
    wait_cyc(20);
    check(pend_cnt == 0 && cfg === m_cfg, "R8 before close", 40'(pend_cnt), 40'd0);
    close_rise();
    wait_cyc(10);
    m_cfg = apply(m_cfg, 1'b1, 8, 40'b0_0110_010);
    check(pend_cnt == 1 && cfg === m_cfg, "R8 after close", cfg, m_cfg);

    // R7 R9: 80-bit chained frame, old chain contents come out first
    pend_cnt = 0;
    sdo_err = 0;
    send(1'b0, 80, {IMG_C, IMG_D}, 1'b1, 1'b1);
    wait_cyc(10);
    m_cfg = IMG_C;
    check(sdo_err == 0, "R9 sdo sequence", 40'(sdo_err), 40'd0);
    check(pend_cnt == 1 && cfg === m_cfg, "R7 long frame", cfg, m_cfg);
    check(sdo === IMG_C[0], "R9 sdo oldest", {39'd0, sdo}, {39'd0, IMG_C[0]});

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule